// File: doc/BRIEF.md
# Scaled Fixed-Point Integer to Single-Precision Converter

This block turns one 32-bit integer lane into an IEEE-754 single-precision value. The integer is read as a fixed-point number whose binary point sits `in_scale` bits above bit 0, so the produced float equals the integer times 2^(-scale). A select chooses between a two's-complement source and an unsigned source in which bit 31 is magnitude. A 2-bit code picks one of four rounding modes for the cases where the magnitude needs more than 24 significant bits.

The datapath has two register stages. The first stage takes the magnitude and sign, counts leading zeros and shifts the magnitude so its top bit is set. The second stage rounds to a 24-bit significand, works out the biased exponent from the leading-zero count and the scale, and registers the packed result together with an inexact flag. One operand can enter on every clock, and each result appears two cycles after its operand.

Top module: `fxp2fp_cvt`

## Requirements
- R1: The output value is the integer value times 2^(-in_scale), with in_scale taken as unsigned 0..31. Each step up in scale lowers the exponent field (bits 30:23) by one and leaves the fraction unchanged. For example, 2^23 at scales 0 and 3 gives 0x4B000000 and 0x49800000.
- R2: When `in_unsigned`=0 the operand is two's complement and the result has sign bit 31 = operand bit 31. 0x80000000 converts exactly to -2^31·2^(-scale), which is 0xCF000000 at scale 0 and 0xBF800000 at scale 31.
- R3: When `in_unsigned`=1, bit 31 is magnitude and the result is never negative. 0x80000000 gives 0x4F000000 with inexact clear. 0xFFFFFFFF gives 0x4F7FFFFF (4294967040.0) with inexact set under toward-zero.
- R4: Mode code 00 rounds to nearest with ties to even. 16777219 gives 0x4B800002 (16777220), 2^24+1 gives 0x4B800000, and unsigned 0xFFFFFFFF rounds up to 0x4F800000.
- R5: Mode code 01 rounds toward zero. 16777219 gives 0x4B800001 (16777218), and signed 0x7FFFFFFF gives 0x4EFFFFFF.
- R6: Mode code 10 rounds toward +infinity and code 11 rounds toward -infinity, both acting on the signed value. -16777219 gives 0xCB800001 under 10 and 0xCB800002 under 11.
- R7: A zero operand gives +0.0 (0x00000000) with inexact clear, for every scale, mode and signedness.
- R8: `out_inexact` is 1 exactly when nonzero bits of the magnitude fall below the 24-bit significand. Magnitudes up to 2^24 convert exactly, and 2^24+1 raises inexact.
- R9: The result and flag of an operand accepted with `in_valid`=1 appear two clock cycles later with `out_valid`=1. Back-to-back operands are accepted on consecutive cycles. A synchronous reset clears `out_valid`, `out_result` and `out_inexact` to 0.
- R10: For a nonzero result the biased exponent field stays within 96..159 for all scales, so no overflow, underflow or subnormal result arises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_word | input | 32 | Integer operand |
| in_unsigned | input | 1 | 1: operand unsigned, 0: two's complement |
| in_scale | input | 5 | Fixed-point scale exponent, result divided by 2^scale |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result present, two cycles after the operand |
| out_result | output | 32 | Single-precision result |
| out_inexact | output | 1 | Nonzero bits were discarded by rounding |

## Verification
The clocked assertions compare outputs with the inputs presented two cycles earlier. They therefore assume that `in_valid` and the operand fields are driven to known values on every cycle once reset is released, and that reset is held for at least two cycles. The stimulus meets this by driving every input to zero during reset, changing inputs only on the falling edge, and holding `in_valid` low between operands with the fields kept defined. The normalisation check assumes that a nonzero operand always has a nonzero magnitude after negation. The one value that could break this is 0x80000000 in signed mode, so the stimulus applies that value explicitly.

// File: rtl/fxp2fp_pkg.sv
package fxp2fp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rmode_e;

  function automatic logic round_up(input rmode_e mode, input logic neg,
                                    input logic lsb, input logic guard,
                                    input logic sticky);
    case (mode)
      RM_NEAR_EVEN: round_up = guard & (sticky | lsb);
      RM_TO_ZERO:   round_up = 1'b0;
      RM_TO_POS:    round_up = (guard | sticky) & ~neg;
      default:      round_up = (guard | sticky) & neg;
    endcase
  endfunction

endpackage

// File: rtl/fxp2fp_lzc.sv
module fxp2fp_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fxp2fp_norm.sv
module fxp2fp_norm #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  input  logic          is_unsigned,
  output logic          neg,
  output logic [W-1:0]  mag_norm,
  output logic [CW-1:0] lead_zeros
);
  logic [W-1:0] mag;

  assign neg = ~is_unsigned & word[W-1];
  assign mag = neg ? (~word + W'(1)) : word;

  fxp2fp_lzc #(.W(W), .CW(CW)) u_lzc (
    .vec   (mag),
    .count (lead_zeros)
  );

  assign mag_norm = mag << lead_zeros;
endmodule

// File: rtl/fxp2fp_round.sv
module fxp2fp_round
  import fxp2fp_pkg::*;
#(
  parameter int W       = 32,
  parameter int CW      = $clog2(W + 1),
  parameter int SCALE_W = 5,
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23
) (
  input  logic               neg,
  input  logic [W-1:0]       mag_norm,
  input  logic [CW-1:0]      lead_zeros,
  input  logic [SCALE_W-1:0] scale,
  input  rmode_e             mode,
  output logic [EXP_W+FRAC_W:0] result,
  output logic               inexact
);
  localparam int SIG_W    = FRAC_W + 1;
  localparam int DROP     = W - SIG_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_BASE = W - 1 + BIAS;

  logic [SIG_W-1:0] sig;
  logic             guard, sticky, inc;
  logic [SIG_W:0]   sum;
  logic             carry, nonzero;
  logic [EXP_W-1:0] exp_field;

  assign sig    = mag_norm[W-1 -: SIG_W];
  assign guard  = mag_norm[DROP-1];
  assign sticky = |mag_norm[DROP-2:0];
  assign inc    = round_up(mode, neg, sig[0], guard, sticky);
  assign sum    = {1'b0, sig} + (SIG_W + 1)'(inc);
  assign carry  = sum[SIG_W];
  // top bit of the normalised magnitude set (or carried) means nonzero
  assign nonzero = sum[SIG_W] | sum[SIG_W-1];

  assign exp_field = EXP_W'(EXP_BASE) - EXP_W'(lead_zeros)
                   - EXP_W'(scale) + EXP_W'(carry);

  // on carry the low fraction bits of sum are already zero
  assign result  = nonzero ? {neg, exp_field, sum[FRAC_W-1:0]} : '0;
  assign inexact = nonzero & (guard | sticky);
endmodule

// File: rtl/fxp2fp_cvt.sv
module fxp2fp_cvt
  import fxp2fp_pkg::*;
#(
  parameter int W       = 32,
  parameter int SCALE_W = 5,
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [W-1:0]       in_word,
  input  logic               in_unsigned,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [1:0]         in_rmode,
  output logic               out_valid,
  output logic [EXP_W+FRAC_W:0] out_result,
  output logic               out_inexact
);
  localparam int CW      = $clog2(W + 1);
  localparam int RES_W   = EXP_W + FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MIN = BIAS - ((1 << SCALE_W) - 1);
  localparam int EXP_MAX = BIAS + W;

  // stage 1: normalise
  logic          n_neg;
  logic [W-1:0]  n_mag;
  logic [CW-1:0] n_lz;

  fxp2fp_norm #(.W(W), .CW(CW)) u_norm (
    .word        (in_word),
    .is_unsigned (in_unsigned),
    .neg         (n_neg),
    .mag_norm    (n_mag),
    .lead_zeros  (n_lz)
  );

  logic               s1_valid, s1_neg;
  logic [W-1:0]       s1_mag;
  logic [CW-1:0]      s1_lz;
  logic [SCALE_W-1:0] s1_scale;
  rmode_e             s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_neg   <= 1'b0;
      s1_mag   <= '0;
      s1_lz    <= '0;
      s1_scale <= '0;
      s1_mode  <= RM_NEAR_EVEN;
    end else begin
      s1_valid <= in_valid;
      s1_neg   <= n_neg;
      s1_mag   <= n_mag;
      s1_lz    <= n_lz;
      s1_scale <= in_scale;
      s1_mode  <= rmode_e'(in_rmode);
    end
  end

  // shifter and leading-zero counter must agree: top bit set or all zero (R8)
  assert_norm_msb_R8: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && (s1_mag != '0)) |-> s1_mag[W-1]);

  // stage 2: round and pack
  logic [RES_W-1:0] r_result;
  logic             r_inexact;

  fxp2fp_round #(
    .W(W), .CW(CW), .SCALE_W(SCALE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)
  ) u_round (
    .neg        (s1_neg),
    .mag_norm   (s1_mag),
    .lead_zeros (s1_lz),
    .scale      (s1_scale),
    .mode       (s1_mode),
    .result     (r_result),
    .inexact    (r_inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
    end else begin
      out_valid   <= s1_valid;
      out_result  <= r_result;
      out_inexact <= r_inexact;
    end
  end

  // R9: two-cycle latency of the valid
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

  // R7: zero in gives +0 with no inexact
  assert_zero_result_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(in_valid, 2) && ($past(in_word, 2) == '0))
    |-> (out_result == '0 && !out_inexact));

  // R2 / R3: sign bit follows the operand and the signedness select
  assert_sign_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(in_valid, 2) && ($past(in_word, 2) != '0))
    |-> (out_result[RES_W-1] == ($past(in_word[W-1], 2) & !$past(in_unsigned, 2))));

  assert_unsigned_pos_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(in_valid, 2) && $past(in_unsigned, 2))
    |-> !out_result[RES_W-1]);

  // R10: exponent field bounded for every nonzero result
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_result[RES_W-2:0] != '0))
    |-> ((int'(out_result[RES_W-2 -: EXP_W]) >= EXP_MIN) &&
         (int'(out_result[RES_W-2 -: EXP_W]) <= EXP_MAX)));
endmodule

// File: tb/fxp2fp_cvt_bench.sv
`timescale 1ns/1ps
module fxp2fp_cvt_bench;

  typedef struct packed {
    logic [31:0] word;
    logic        uns;
    logic [4:0]  scale;
    logic [1:0]  rm;
    logic [31:0] res;
    logic        inx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'h00000000, 1'b0, 5'd0,  2'd0, 32'h00000000, 1'b0, 4'd7},  // R7
    '{32'h00000000, 1'b1, 5'd17, 2'd3, 32'h00000000, 1'b0, 4'd7},  // R7
    '{32'h00800000, 1'b0, 5'd0,  2'd0, 32'h4B000000, 1'b0, 4'd1},  // R1
    '{32'h00800000, 1'b0, 5'd3,  2'd0, 32'h49800000, 1'b0, 4'd1},  // R1
    '{32'h00000001, 1'b0, 5'd31, 2'd0, 32'h30000000, 1'b0, 4'd1},  // R1
    '{32'h00000003, 1'b0, 5'd1,  2'd0, 32'h3FC00000, 1'b0, 4'd1},  // R1
    '{32'hFFFFFFFF, 1'b0, 5'd0,  2'd0, 32'hBF800000, 1'b0, 4'd2},  // R2
    '{32'h80000000, 1'b0, 5'd0,  2'd0, 32'hCF000000, 1'b0, 4'd2},  // R2
    '{32'h80000000, 1'b0, 5'd31, 2'd0, 32'hBF800000, 1'b0, 4'd2},  // R2
    '{32'h80000000, 1'b1, 5'd0,  2'd0, 32'h4F000000, 1'b0, 4'd3},  // R3
    '{32'hFFFFFFFF, 1'b1, 5'd0,  2'd1, 32'h4F7FFFFF, 1'b1, 4'd3},  // R3
    '{32'hFFFFFFFF, 1'b1, 5'd31, 2'd1, 32'h3FFFFFFF, 1'b1, 4'd3},  // R3
    '{32'hFFFFFFFF, 1'b1, 5'd0,  2'd0, 32'h4F800000, 1'b1, 4'd4},  // R4
    '{32'h01000000, 1'b0, 5'd0,  2'd0, 32'h4B800000, 1'b0, 4'd8},  // R8
    '{32'h01000001, 1'b0, 5'd0,  2'd0, 32'h4B800000, 1'b1, 4'd8},  // R8
    '{32'h01000003, 1'b0, 5'd0,  2'd0, 32'h4B800002, 1'b1, 4'd4},  // R4
    '{32'h7FFFFFFF, 1'b0, 5'd0,  2'd0, 32'h4F000000, 1'b1, 4'd4},  // R4
    '{32'h01000003, 1'b0, 5'd0,  2'd1, 32'h4B800001, 1'b1, 4'd5},  // R5
    '{32'h7FFFFFFF, 1'b0, 5'd0,  2'd1, 32'h4EFFFFFF, 1'b1, 4'd5},  // R5
    '{32'h01000001, 1'b0, 5'd0,  2'd2, 32'h4B800001, 1'b1, 4'd6},  // R6
    '{32'hFEFFFFFD, 1'b0, 5'd0,  2'd2, 32'hCB800001, 1'b1, 4'd6},  // R6
    '{32'hFEFFFFFD, 1'b0, 5'd0,  2'd3, 32'hCB800002, 1'b1, 4'd6},  // R6
    '{32'h00800000, 1'b0, 5'd0,  2'd2, 32'h4B000000, 1'b0, 4'd6},  // R6
    '{32'h00000005, 1'b1, 5'd2,  2'd3, 32'h3FA00000, 1'b0, 4'd1}   // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_unsigned = 1'b0;
  logic [4:0]  in_scale = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fxp2fp_cvt u_fxp2fp_cvt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_unsigned(in_unsigned), .in_scale(in_scale), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_result(out_result), .out_inexact(out_inexact)
  );

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic u,
                       input logic [4:0] s, input logic [1:0] m);
    in_valid = v; in_word = w; in_unsigned = u; in_scale = s; in_rmode = m;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 reset valid",   {31'b0, out_valid}, 32'h0);
    check("R9 reset result",  out_result, 32'h0);
    check("R9 reset inexact", {31'b0, out_inexact}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // streamed table: vector k driven at negedge k, seen at negedge k+2 (R9)
    for (int k = 0; k < NV + 2; k++) begin
      if (k >= 2) begin
        vec_t e;
        e = VECS[k-2];
        check($sformatf("R%0d valid vec %0d", e.req, k-2), {31'b0, out_valid}, 32'h1);
        check($sformatf("R%0d result vec %0d", e.req, k-2), out_result, e.res);
        check($sformatf("R%0d inexact vec %0d", e.req, k-2), {31'b0, out_inexact}, {31'b0, e.inx});
      end
      if (k < NV) drive(1'b1, VECS[k].word, VECS[k].uns, VECS[k].scale, VECS[k].rm);
      else        drive(1'b0, 32'h0, 1'b0, 5'd0, 2'd0);
      @(negedge clk);
    end
    // R9 bubble: valid drops once the stream ends
    check("R9 valid after stream", {31'b0, out_valid}, 32'h0);

    // R1 scale sweep: 2^23 at every scale, exponent 150 - s
    for (int s = 0; s < 32; s++) begin
      drive(1'b1, 32'h00800000, 1'b0, 5'(s), 2'd0);
      @(negedge clk);
      drive(1'b0, 32'h0, 1'b0, 5'd0, 2'd0);
      @(negedge clk);
      check($sformatf("R1 scale %0d", s), out_result, {1'b0, 8'(150 - s), 23'b0});
    end

    // R7 zero over every mode, negative-looking scale settings
    for (int m = 0; m < 4; m++) begin
      drive(1'b1, 32'h0, 1'b0, 5'd31, 2'(m));
      @(negedge clk);
      drive(1'b0, 32'h0, 1'b0, 5'd0, 2'd0);
      @(negedge clk);
      check($sformatf("R7 zero mode %0d", m), {out_inexact, out_result[30:0]}, 32'h0);
    end

    // R9 synchronous reset clears a pending result
    drive(1'b1, 32'h00000007, 1'b0, 5'd0, 2'd0);
    @(negedge clk);
    drive(1'b0, 32'h0, 1'b0, 5'd0, 2'd0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 reset mid-flight", {out_valid, out_result[30:0]}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule